// File: doc/BRIEF.md
# Pipelined burst synchronous SRAM

This block is a synthesizable model of a synchronous static memory. It takes address and control on one rising clock edge and moves the data two enabled edges later. Reads and writes use the same two-cycle offset, so the data bus never needs an idle cycle when the direction changes. A read can follow a write, or a write a read, on consecutive cycles.

Each enabled cycle either loads a fresh operation from the address and control pins or advances a two-bit burst counter. The counter works on the two lowest address bits only and leaves the upper bits fixed. A mode pin selects the burst order, counting up or stepping by XOR, and the counter wraps after four addresses. Writes are split into four 9-bit byte lanes, each with its own active-low enable. The data bus is presented as separate input, output and output-enable ports. The stored array covers 2^MEM_AW words, and any address bits above that alias onto it.

Top module: `pipe_burst_sram`

## Requirements
- R1: From reset until the first read data phase, dq_oe is 0.
- R2: A read is loaded on an enabled rising edge k when clk_en_n=0, adv_ld=0, wr_n=1 and the chip is selected. dq_oe is then 1 and dq_o holds the stored word for the single cycle after enabled edge k+2. Edges count as enabled only when clk_en_n=0.
- R3: A write is loaded on enabled edge k with wr_n=0. It stores the dq_i value sampled on enabled edge k+2. Operations may be loaded on every cycle with no idle cycle between them, and a read loaded after a write returns the written data.
- R4: Lane i is dq bits [9i+8:9i]. It is written only when bwe_n[i] was 0 in the same cycle as the address of that write. Lanes with bwe_n[i]=1 keep their old contents.
- R5: With mode_il=0 the low address bits of a burst run start, start+1, start+2, start+3 (modulo 4). Address bits above bit 1 stay those of the load.
- R6: With mode_il=1 the low address bits of a burst are start XOR 0, 1, 2, 3 in turn.
- R7: The advance after the fourth address of a burst returns to the start address, and the burst continues in the same order.
- R8: On a cycle with adv_ld=1, wr_n and addr are ignored. The burst keeps the read or write kind of its load.
- R9: The chip is selected only when cs1_n=0, cs2=1 and cs3_n=0 on a load. A load without selection starts an idle state in which nothing is stored and dq_oe stays 0. Advances that follow the idle load also do nothing.
- R10: While clk_en_n=1 no state changes. The outputs hold their values, pending data phases wait, and the burst counter does not step.
- R11: dq_oe is 0 during the data phase of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clk_en_n | input | 1 | Active-low clock enable for the whole pipeline |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 1 advances the burst, 0 loads a new operation |
| wr_n | input | 1 | 0 write, 1 read (on loads) |
| bwe_n | input | 4 | Active-low byte-lane write enables |
| mode_il | input | 1 | Burst order: 0 linear, 1 XOR-stepped |
| addr | input | 17 | Word address |
| dq_i | input | 36 | Write data bus |
| dq_o | output | 36 | Read data bus |
| dq_oe | output | 1 | Output driver enable for dq_o |

## Verification
Back-to-back loads of write, write, read and read at two addresses show that both directions share one two-cycle offset and need no idle cycle. A full write followed at once by a partial write to the same word shows which lanes each enable controls. The burst tests start at low bits 01 for writes and 11 for reads, where linear and XOR order give different address sequences. A fifth write in a linear burst lands on the start address, which shows the wrap. Further tests flip wr_n during advances, make deselected loads that carry write data, and insert clock-enable stalls both between reads and inside a burst. The stall test shows that the counter and the pending phases freeze rather than run on.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  localparam int CNT_W = 2;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_ord_e;

  // Low address bits for burst step 'step' from start value 'start'.
  function automatic logic [CNT_W-1:0] burst_lo(
    input logic [CNT_W-1:0] start,
    input logic [CNT_W-1:0] step,
    input burst_ord_e       ord
  );
    if (ord == ORD_XOR) return start ^ step;
    return start + step;
  endfunction

endpackage

// File: rtl/pbs_burst.sv
module pbs_burst
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              adv_ld,
  input  logic              sel,
  input  logic              wr_n,
  input  logic              mode_il,
  input  logic [ADDR_W-1:0] addr,
  output logic              op_vld,
  output logic              op_wr,
  output logic [ADDR_W-1:0] op_adr
);

  localparam int HI_W = ADDR_W - CNT_W;

  logic             act_q, act_d;
  logic             wr_q, wr_d;
  logic [HI_W-1:0]  hi_q, hi_d;
  logic [CNT_W-1:0] lo_q, lo_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!adv_ld) begin
      act_d = sel;
      wr_d  = ~wr_n;
      hi_d  = addr[ADDR_W-1:CNT_W];
      lo_d  = addr[CNT_W-1:0];
      cnt_d = '0;
    end else begin
      act_d = act_q;
      wr_d  = wr_q;
      hi_d  = hi_q;
      lo_d  = lo_q;
      cnt_d = act_q ? cnt_q + 1'b1 : cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      wr_q  <= 1'b0;
      hi_q  <= '0;
      lo_q  <= '0;
      cnt_q <= '0;
    end else if (en) begin
      act_q <= act_d;
      wr_q  <= wr_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      cnt_q <= cnt_d;
    end
  end

  assign op_vld = act_d;
  assign op_wr  = wr_d;
  assign op_adr = {hi_d, burst_lo(lo_d, cnt_d, burst_ord_e'(mode_il))};

endmodule

// File: rtl/pbs_pipe.sv
module pbs_pipe #(
  parameter int ADDR_W = 17,
  parameter int MEM_AW = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              in_vld,
  input  logic              in_wr,
  input  logic [ADDR_W-1:0] in_adr,
  input  logic [LANES-1:0]  in_be_n,
  output logic              hd_vld,
  output logic              hd_wr,
  output logic [ADDR_W-1:0] hd_adr,
  output logic              tl_vld,
  output logic              tl_wr,
  output logic [MEM_AW-1:0] tl_idx,
  output logic [LANES-1:0]  tl_be_n
);

  logic              s1_vld, s1_wr;
  logic [ADDR_W-1:0] s1_adr;
  logic [LANES-1:0]  s1_be_n;
  logic              s2_vld, s2_wr;
  logic [MEM_AW-1:0] s2_idx;
  logic [LANES-1:0]  s2_be_n;

  // Stage 1: the address/control cycle just sampled.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_wr   <= 1'b0;
      s1_adr  <= '0;
      s1_be_n <= '1;
    end else if (en) begin
      s1_vld  <= in_vld;
      s1_wr   <= in_wr;
      s1_adr  <= in_adr;
      s1_be_n <= in_be_n;
    end
  end

  // Stage 2: the operation whose data moves on the next enabled edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld  <= 1'b0;
      s2_wr   <= 1'b0;
      s2_idx  <= '0;
      s2_be_n <= '1;
    end else if (en) begin
      s2_vld  <= s1_vld;
      s2_wr   <= s1_wr;
      s2_idx  <= s1_adr[MEM_AW-1:0];
      s2_be_n <= s1_be_n;
    end
  end

  assign hd_vld  = s1_vld;
  assign hd_wr   = s1_wr;
  assign hd_adr  = s1_adr;
  assign tl_vld  = s2_vld;
  assign tl_wr   = s2_wr;
  assign tl_idx  = s2_idx;
  assign tl_be_n = s2_be_n;

endmodule

// File: rtl/pbs_array.sv
module pbs_array #(
  parameter  int MEM_AW = 8,
  parameter  int LANES  = 4,
  parameter  int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              vld,
  input  logic              wr,
  input  logic [MEM_AW-1:0] idx,
  input  logic [LANES-1:0]  be_n,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rd,
  output logic              oe
);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] old_w;
  logic [DATA_W-1:0] merged;
  logic              wr_fire;
  logic              oe_q, oe_d;
  logic [DATA_W-1:0] rd_q, rd_d;

  assign old_w   = mem_q[idx];
  assign wr_fire = en & vld & wr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign merged[g*LANE_W +: LANE_W] =
      be_n[g] ? old_w[g*LANE_W +: LANE_W] : wd[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (wr_fire) mem_q[idx] <= merged;
  end

  always_comb begin
    oe_d = vld & ~wr;
    rd_d = oe_d ? old_w : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= 1'b0;
      rd_q <= '0;
    end else if (en) begin
      oe_q <= oe_d;
      rd_q <= rd_d;
    end
  end

  assign oe = oe_q;
  assign rd = rd_q;

  // R11
  wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && vld && wr) |=> !oe);

  // R2
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && vld && !wr) |=> oe);

endmodule

// File: rtl/pipe_burst_sram.sv
module pipe_burst_sram #(
  parameter  int ADDR_W = 17,
  parameter  int LANES  = 4,
  parameter  int LANE_W = 9,
  parameter  int MEM_AW = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              adv_ld,
  input  logic              wr_n,
  input  logic [LANES-1:0]  bwe_n,
  input  logic              mode_il,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe
);

  logic              en, sel;
  logic              op_vld, op_wr;
  logic [ADDR_W-1:0] op_adr;
  logic              hd_vld, hd_wr;
  logic [ADDR_W-1:0] hd_adr;
  logic              tl_vld, tl_wr;
  logic [MEM_AW-1:0] tl_idx;
  logic [LANES-1:0]  tl_be_n;

  assign en  = ~clk_en_n;
  assign sel = ~cs1_n & cs2 & ~cs3_n;

  pbs_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .adv_ld  (adv_ld),
    .sel     (sel),
    .wr_n    (wr_n),
    .mode_il (mode_il),
    .addr    (addr),
    .op_vld  (op_vld),
    .op_wr   (op_wr),
    .op_adr  (op_adr)
  );

  pbs_pipe #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .LANES(LANES)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .in_vld  (op_vld),
    .in_wr   (op_wr),
    .in_adr  (op_adr),
    .in_be_n (bwe_n),
    .hd_vld  (hd_vld),
    .hd_wr   (hd_wr),
    .hd_adr  (hd_adr),
    .tl_vld  (tl_vld),
    .tl_wr   (tl_wr),
    .tl_idx  (tl_idx),
    .tl_be_n (tl_be_n)
  );

  pbs_array #(.MEM_AW(MEM_AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .vld   (tl_vld),
    .wr    (tl_wr),
    .idx   (tl_idx),
    .be_n  (tl_be_n),
    .wd    (dq_i),
    .rd    (dq_o),
    .oe    (dq_oe)
  );

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(dq_o) && $stable(dq_oe)));

  // R9
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !adv_ld && !sel) |=> !hd_vld);

  // R8
  keep_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv_ld) |=> (hd_wr == $past(hd_wr)));

  // R5, R6: every burst step flips address bit 0 in both orders
  lsb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv_ld && hd_vld) |=> (hd_adr[0] != $past(hd_adr[0])));

  // R5
  upper_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv_ld && hd_vld) |=> (hd_adr[ADDR_W-1:2] == $past(hd_adr[ADDR_W-1:2])));

endmodule

// File: tb/tb_pipe_burst_sram.sv
`timescale 1ns/1ps
module tb_pipe_burst_sram;

  localparam int AW = 17;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en_n, cs1_n, cs2, cs3_n, adv_ld, wr_n, mode_il;
  logic [LN-1:0] bwe_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_i, dq_o;
  logic          dq_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  pipe_burst_sram dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .cs1_n(cs1_n), .cs2(cs2),
    .cs3_n(cs3_n), .adv_ld(adv_ld), .wr_n(wr_n), .bwe_n(bwe_n),
    .mode_il(mode_il), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
  );

  task automatic check(input string tag, input bit ok,
                       input logic [DW:0] act, input logic [DW:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual={oe,data}=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [DW-1:0] exp);
    check(tag, (dq_oe === 1'b1) && (dq_o === exp), {dq_oe, dq_o}, {1'b1, exp});
  endtask

  task automatic chk_idle(input string tag);
    check(tag, dq_oe === 1'b0, {dq_oe, dq_o}, {1'b0, dq_o});
  endtask

  // One cycle: set inputs after a falling edge, return at the next one.
  task automatic drv(input logic adv, input logic wn, input logic [AW-1:0] a,
                     input logic [LN-1:0] be, input logic [DW-1:0] wd,
                     input logic [2:0] cs);
    clk_en_n = 1'b0;
    adv_ld = adv; wr_n = wn; addr = a; bwe_n = be; dq_i = wd;
    {cs1_n, cs2, cs3_n} = cs;
    @(negedge clk);
  endtask

  task automatic ld_wr(input logic [AW-1:0] a, input logic [DW-1:0] wd);
    drv(1'b0, 1'b0, a, '0, wd, 3'b010);
  endtask
  task automatic ld_rd(input logic [AW-1:0] a, input logic [DW-1:0] wd);
    drv(1'b0, 1'b1, a, '0, wd, 3'b010);
  endtask
  task automatic step(input logic wn, input logic [DW-1:0] wd);
    drv(1'b1, wn, 17'h1ffff, '0, wd, 3'b010);
  endtask
  task automatic nop(input logic [DW-1:0] wd);
    drv(1'b0, 1'b0, '0, '0, wd, 3'b000);
  endtask
  task automatic stall();
    clk_en_n = 1'b1;
    adv_ld = 1'b0; wr_n = 1'b0; addr = 17'h00030; bwe_n = '0; dq_i = '1;
    {cs1_n, cs2, cs3_n} = 3'b010;
    @(negedge clk);
    clk_en_n = 1'b0;
  endtask

  localparam logic [DW-1:0] D0 = 36'h1_0203_0405;
  localparam logic [DW-1:0] D1 = 36'hA_BCDE_F012;

  task automatic t_reset();
    chk_idle("R1 oe after reset");
    nop('0);
    chk_idle("R1 oe first cycle");
    nop('0);
    chk_idle("R1 oe second cycle");
  endtask

  task automatic t_back_to_back();
    mode_il = 1'b0;
    ld_wr(17'h00010, '0);
    ld_wr(17'h00024, '0);
    ld_rd(17'h00010, D0);
    chk_idle("R11 write phase 1");
    ld_rd(17'h00024, D1);
    chk_idle("R11 write phase 2");
    nop('0);
    chk_rd("R2 R3 read after write 0x10", D0);
    nop('0);
    chk_rd("R2 R3 read after write 0x24", D1);
    nop('0);
    chk_idle("R2 single read cycle");
  endtask

  task automatic t_lanes();
    logic [DW-1:0] f, n, e;
    f = 36'hF_0F0F_0F0F;
    n = 36'h5_A5A5_A5A5;
    for (int l = 0; l < LN; l++)
      e[l*LW +: LW] = (l == 0 || l == 2) ? n[l*LW +: LW] : f[l*LW +: LW];
    ld_wr(17'h00030, '0);
    drv(1'b0, 1'b0, 17'h00030, 4'b1010, '0, 3'b010);
    nop(f);
    ld_rd(17'h00030, n);
    nop('0);
    nop('0);
    chk_rd("R4 lanes 0 and 2 written", e);
  endtask

  task automatic t_linear();
    logic [DW-1:0] d [5];
    for (int i = 0; i < 5; i++) d[i] = 36'h4_0000_0000 + DW'(i * 17 + 3);
    mode_il = 1'b0;
    ld_wr(17'h00041, '0);
    step(1'b0, '0);
    step(1'b0, d[0]);
    step(1'b0, d[1]);
    step(1'b0, d[2]);
    nop(d[3]);
    nop(d[4]);
    ld_rd(17'h00040, '0);
    ld_rd(17'h00041, '0);
    ld_rd(17'h00042, '0);
    chk_rd("R5 linear fourth address 0x40", d[3]);
    ld_rd(17'h00043, '0);
    chk_rd("R7 wrap rewrote start 0x41", d[4]);
    nop('0);
    chk_rd("R5 linear second address 0x42", d[1]);
    nop('0);
    chk_rd("R5 linear third address 0x43", d[2]);
  endtask

  task automatic t_xor();
    logic [DW-1:0] e [4];
    for (int i = 0; i < 4; i++) e[i] = 36'h7_1000_0000 + DW'(i * 5 + 1);
    mode_il = 1'b1;
    // start 01: 51, 50, 53, 52; wr_n high on advances must not matter
    ld_wr(17'h00051, '0);
    step(1'b1, '0);
    step(1'b1, e[0]);
    step(1'b1, e[1]);
    nop(e[2]);
    nop(e[3]);
    // read burst from 11: 53, 52, 51, 50; wr_n low on advances
    ld_rd(17'h00053, '0);
    step(1'b0, '0);
    step(1'b0, '0);
    chk_rd("R6 R8 xor first 0x53", e[2]);
    step(1'b0, '0);
    chk_rd("R6 R8 xor second 0x52", e[3]);
    nop('0);
    chk_rd("R6 xor third 0x51", e[0]);
    nop('0);
    chk_rd("R6 xor fourth 0x50", e[1]);
    nop('0);
    chk_idle("R9 idle after burst");
  endtask

  task automatic t_desel();
    logic [DW-1:0] a, b;
    a = 36'h3_3333_3333;
    b = 36'hC_CCCC_CCCC;
    mode_il = 1'b0;
    ld_wr(17'h00060, '0);
    nop('0);
    nop(a);
    drv(1'b0, 1'b0, 17'h00060, '0, '0, 3'b011);
    step(1'b0, '0);
    nop(b);
    chk_idle("R9 deselected load phase");
    drv(1'b0, 1'b0, 17'h00061, '0, b, 3'b000);
    chk_idle("R9 advance after deselect phase");
    drv(1'b0, 1'b0, 17'h00060, '0, b, 3'b110);
    nop(b);
    ld_rd(17'h00060, b);
    nop('0);
    nop('0);
    chk_rd("R9 no write while deselected", a);
  endtask

  task automatic t_hold();
    mode_il = 1'b0;
    ld_rd(17'h00010, '0);
    ld_rd(17'h00024, '0);
    nop('0);
    chk_rd("R10 before stall", D0);
    stall();
    chk_rd("R10 output held in stall", D0);
    nop('0);
    chk_rd("R10 pending read after stall", D1);
    nop('0);
    chk_idle("R10 pipeline drained");
    // burst 41 -> stall -> advance must give 42, not 43
    ld_rd(17'h00041, '0);
    stall();
    step(1'b1, '0);
    nop('0);
    chk_rd("R10 burst start after stall", 36'h4_0000_0000 + DW'(4 * 17 + 3));
    nop('0);
    chk_rd("R10 counter held during stall", 36'h4_0000_0000 + DW'(1 * 17 + 3));
  endtask

  initial begin
    rst_n = 1'b0; clk_en_n = 1'b0; cs1_n = 1'b1; cs2 = 1'b0; cs3_n = 1'b1;
    adv_ld = 1'b0; wr_n = 1'b1; bwe_n = '1; mode_il = 1'b0; addr = '0; dq_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_back_to_back();
    t_lanes();
    t_linear();
    t_xor();
    t_desel();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog (all R) actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule